// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Access Controller

This block sits between a clocked request port and an external asynchronous static RAM with a byte-wide data bus. Each request is a single read or a single write. The block latches the request, drives the RAM address and the three active-low strobes, and counts clock cycles so that the RAM's nanosecond limits are met. For a read, it returns the captured byte with a one-cycle valid pulse.

The RAM's minimum access time, write pulse width, data setup and bus release time are parameters given in nanoseconds, together with the clock period. The block rounds each one up to a whole number of clock cycles.

The sequence is ordered so that the bus handoff is safe:
- The address never moves while a strobe is active.
- Output enable is never low during a write.
- The block drives the data bus only while write enable is low.
- A write that follows a read waits for the RAM's drivers to turn off.

Top module: `sram_ctl`

## Requirements
- R1: After reset and whenever no access is in progress, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are all 1, `mem_dq_oe` is 0 and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle, `req_ready` stays 0 until the access ends. While any strobe is low, `mem_addr` equals the accepted `req_addr`.
- R3: A read drives `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD cycles. The byte on `mem_dq_i` in the last of those cycles appears on `rsp_rdata`, together with a `rsp_valid` pulse one cycle wide. That pulse is high in the (RD+1)-th cycle after the accepting edge, which is also the first cycle with `req_ready` back at 1.
- R4: A write has three phases:
  - One setup cycle with `mem_ce_n`=0 and `mem_we_n`=1.
  - Exactly WP cycles with `mem_we_n`=0 and `mem_dq_o` equal to the accepted `req_wdata`.
  - One recovery cycle with all strobes at 1.

  Without a turnaround, `req_ready` returns in the (WP+3)-th cycle after acceptance.
- R5: `mem_oe_n` is 1 in every cycle of a write, so `mem_oe_n` and `mem_we_n` are never both 0.
- R6: `mem_dq_oe` is 1 only in cycles where `mem_we_n` is 0.
- R7: When a write is accepted and the previous completed access was a read, TA extra cycles with all strobes at 1 and `mem_dq_oe`=0 come before the setup cycle. A write that follows a write has no such gap.
- R8: `mem_addr` changes only across an edge where `mem_ce_n` was 1 before the edge and `mem_we_n` is 1 after it.
- R9: The cycle counts use ceil(t/CLK_NS) with a minimum of 1:
  - RD comes from max(T_RC, T_AA).
  - WP comes from the larger of the counts for T_WP and T_DW.
  - TA comes from T_OHZ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (19) | Word address |
| req_wdata | input | DATA_W (8) | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W (8) | Read byte |
| mem_addr | output | ADDR_W (19) | RAM address pins |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_o | output | DATA_W (8) | Value driven onto the RAM data bus |
| mem_dq_oe | output | 1 | Tri-state enable for `mem_dq_o` |
| mem_dq_i | input | DATA_W (8) | Value read from the RAM data bus |

## Verification
The read-completion pulse and the acceptance of the next request can land in the same cycle: `req_ready` rises in the cycle where `rsp_valid` is high. The bench provokes this by holding the next request valid from that very cycle, and in particular a write immediately after a read. Such a write must both return correct data and start its turnaround from that cycle. A bus monitor judges this in two ways:
- It counts the cycles with output enable high before the data drivers switch on.
- It verifies that no strobe overlap or address movement occurred.

A RAM model in the bench reads the stored bytes back to confirm both accesses.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_WSETUP,
        S_WPULSE,
        S_WRECOV,
        S_TURN
    } seq_state_e;

    // Round a nanosecond limit up to whole clocks, never fewer than one.
    function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                              input int unsigned clk_ns);
        int unsigned c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int unsigned CNT_W    = 2,
    parameter int unsigned MAX_LOAD = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R9
    timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_LOAD));

endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned RD_CYC = 1,
    parameter int unsigned WP_CYC = 1,
    parameter int unsigned TA_CYC = 1,
    parameter int unsigned CNT_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    input  logic              tmr_zero
);
    typedef struct packed {
        seq_state_e        st;
        logic              rd_after;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
    } seq_regs_t;

    seq_regs_t d, q;

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    if (!req_write) begin
                        d.st     = S_READ;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(RD_CYC - 1);
                    end else if (q.rd_after) begin
                        d.st     = S_TURN;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(TA_CYC - 1);
                    end else begin
                        d.st = S_WSETUP;
                    end
                end
            end
            S_READ: begin
                if (tmr_zero) begin
                    d.rdata    = mem_dq_i;
                    d.rvalid   = 1'b1;
                    d.rd_after = 1'b1;
                    d.st       = S_IDLE;
                end
            end
            S_TURN: begin
                if (tmr_zero) begin
                    d.rd_after = 1'b0;
                    d.st       = S_WSETUP;
                end
            end
            S_WSETUP: begin
                d.st     = S_WPULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WP_CYC - 1);
            end
            S_WPULSE: begin
                if (tmr_zero) d.st = S_WRECOV;
            end
            S_WRECOV: d.st = S_IDLE;
            default:  d.st = S_IDLE;
        endcase

        // Pin levels are registered from the next state: no decode glitches.
        d.ce_n  = !(d.st == S_READ || d.st == S_WSETUP || d.st == S_WPULSE);
        d.oe_n  = !(d.st == S_READ);
        d.we_n  = !(d.st == S_WPULSE);
        d.dq_oe =  (d.st == S_WPULSE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= S_IDLE;
            q.ce_n     <= 1'b1;
            q.we_n     <= 1'b1;
            q.oe_n     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == S_IDLE);
    assign rsp_valid = q.rvalid;
    assign rsp_rdata = q.rdata;
    assign mem_addr  = q.addr;
    assign mem_ce_n  = q.ce_n;
    assign mem_we_n  = q.we_n;
    assign mem_oe_n  = q.oe_n;
    assign mem_dq_o  = q.wdata;
    assign mem_dq_oe = q.dq_oe;

    // R5
    oe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R6
    dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    // R3
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    // R7
    turn_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_TURN) |=> (q.st == S_TURN || q.st == S_WSETUP));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CLK_NS = 10,
    parameter int unsigned T_RC   = 8,
    parameter int unsigned T_AA   = 8,
    parameter int unsigned T_WP   = 7,
    parameter int unsigned T_DW   = 5,
    parameter int unsigned T_OHZ  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int unsigned RD_CYC = ns_to_cyc(umax(T_RC, T_AA), CLK_NS);
    localparam int unsigned WP_CYC = umax(ns_to_cyc(T_WP, CLK_NS), ns_to_cyc(T_DW, CLK_NS));
    localparam int unsigned TA_CYC = ns_to_cyc(T_OHZ, CLK_NS);
    localparam int unsigned MAX_C  = umax(RD_CYC, umax(WP_CYC, TA_CYC));
    localparam int unsigned CNT_W  = (MAX_C > 1) ? $clog2(MAX_C) : 1;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    sram_cycle_timer #(
        .CNT_W    (CNT_W),
        .MAX_LOAD (MAX_C - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .RD_CYC (RD_CYC),
        .WP_CYC (WP_CYC),
        .TA_CYC (TA_CYC),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .mem_dq_i  (mem_dq_i),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .tmr_zero  (tmr_zero)
    );

endmodule

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;
    localparam int AW = 19;
    localparam int DW = 8;
    localparam int CLKP  = 20;
    localparam int P_RC  = 50;
    localparam int P_AA  = 45;
    localparam int P_WP  = 30;
    localparam int P_DW  = 25;
    localparam int P_OHZ = 25;

    // R9: expected counts computed here from the stated rounding rule
    localparam int E_RD = (((P_RC > P_AA ? P_RC : P_AA) + CLKP - 1) / CLKP);
    localparam int E_WA = (P_WP + CLKP - 1) / CLKP;
    localparam int E_WB = (P_DW + CLKP - 1) / CLKP;
    localparam int E_WP = (E_WA > E_WB) ? E_WA : E_WB;
    localparam int E_TA = (P_OHZ + CLKP - 1) / CLKP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] rsp_rdata, mem_dq_o, mem_dq_i;
    logic [AW-1:0] mem_addr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [DW-1:0] model [256];
    logic [DW-1:0] refm  [256];

    always #(CLKP/2) clk = ~clk;

    sram_ctl #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLKP), .T_RC(P_RC), .T_AA(P_AA),
        .T_WP(P_WP), .T_DW(P_DW), .T_OHZ(P_OHZ)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // RAM model: drives only in read mode; 8'hEE stands for a floating bus.
    assign mem_dq_i = (!mem_ce_n && !mem_oe_n && mem_we_n) ? model[mem_addr[7:0]] : 8'hEE;

    always @(negedge clk)
        if (rst_n && !mem_ce_n && !mem_we_n && mem_dq_oe)
            model[mem_addr[7:0]] <= mem_dq_o;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bus monitor
    logic [AW-1:0] p_addr;
    logic p_ce_n = 1'b1;
    int   oe_hi_run = 0;
    logic p_dq_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n && !mem_oe_n) chk("R5 oe/we overlap", 1, 0);
            if (mem_dq_oe && mem_we_n)  chk("R6 drive without we", 1, 0);
            if (mem_addr !== p_addr && !(p_ce_n && mem_we_n)) chk("R8 addr move", 1, 0);
            if (mem_dq_oe && !p_dq_oe && oe_hi_run < E_TA) chk("R7 turnaround gap", oe_hi_run, E_TA);
            oe_hi_run = mem_oe_n ? oe_hi_run + 1 : 0;
        end
        p_addr  = mem_addr;
        p_ce_n  = mem_ce_n;
        p_dq_oe = mem_dq_oe;
    end

    task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] dd);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dd;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] dd, input int gap);
        int n = 0;
        int we_lo = 0;
        issue(1'b1, a, dd);
        refm[a[7:0]] = dd;
        forever begin
            @(negedge clk); n++;
            if (n <= gap) begin
                // R7: idle strobes during turnaround
                chk("R7 turn strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
            end else if (n == gap + 1) begin
                // R4: setup cycle
                chk("R4 setup", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b011);
            end
            if (!mem_we_n) begin
                we_lo++;
                chk("R4 dq value", mem_dq_o, dd);
                chk("R2 addr held", mem_addr, a);
            end
            if (req_ready) break;
            if (n > 50) break;
        end
        chk("R4 pulse width", we_lo, E_WP);
        chk("R4 write latency", n, E_WP + 3 + gap);
        chk("R1 idle strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        int n = 0;
        int oe_lo = 0;
        issue(1'b0, a, 8'h00);
        forever begin
            @(negedge clk); n++;
            if (!mem_oe_n) begin
                oe_lo++;
                chk("R3 read strobes", {mem_ce_n, mem_we_n}, 2'b01);
                chk("R2 addr held", mem_addr, a);
            end
            if (rsp_valid || n > 50) break;
            chk("R2 ready low", req_ready, 0);
        end
        chk("R3 read latency", n, E_RD + 1);
        chk("R3 read data", rsp_rdata, refm[a[7:0]]);
        chk("R3 oe width", oe_lo, E_RD);
        chk("R3 ready with pulse", req_ready, 1);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin model[i] = 8'h00; refm[i] = 8'h00; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        chk("R1 reset ready", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {req_ready, rsp_valid}, 2'b10);
        // R4/R7: write->write has no gap, sweep all low address bytes
        for (int a = 0; a < 256; a++)
            do_write(AW'((a << 11) | a), DW'((a * 37 + 5) & 8'hFF), 0);
        // R3: read sweep, back-to-back reads
        for (int a = 0; a < 256; a++)
            do_read(AW'((a << 11) | a));
        // R7: write immediately after read (accepted with the rsp_valid cycle)
        for (int a = 0; a < 64; a++) begin
            do_write(AW'(a * 3), DW'(~a), E_TA);
            do_write(AW'(a * 3 + 1), DW'(a ^ 8'h5A), 0);
            do_read(AW'(a * 3));
            do_read(AW'(a * 3 + 1));
        end
        // R7: idle gap after a read does not remove the turnaround
        repeat (5) @(negedge clk);
        do_write(AW'(200), 8'hC3, E_TA);
        do_read(AW'(200));
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule